// File: doc/BRIEF.md
# Exception Entry and Vector Unit

This block performs the state update a processor core makes when it takes an exception. The core presents a one-cycle request carrying an enumerated cause, the address of the faulting instruction, a flag telling whether that instruction sits in a branch delay slot, and a 64-bit capability base. On the next clock edge the block records the return address and the branch-delay flag, reports the 5-bit cause code, raises the exception level, and issues a redirect address with a one-cycle valid pulse that the fetch stage follows.

The block owns the exception-level and boot-vector status bits. The surrounding core rewrites them through a status load port, for example when software writes the status register or when an exception return clears the exception level. The redirect address is the selected vector base plus a sign-extended vector offset, minus the capability base, so that the address lands on the right absolute vector once the core adds its code-capability base back in.

Top module: `exc_entry_unit`

## Requirements
- R1: When `status_exl` is 1 at the edge where `exc_req` is sampled, `epc` and `cause_bd` keep their previous values.
- R2: When `status_exl` is 0 at a sampled request, `epc` becomes `cur_pc` minus 4 and `cause_bd` becomes 1 if `in_delay_slot` is 1; otherwise `epc` becomes `cur_pc` and `cause_bd` becomes 0.
- R3: `exc_cause` is encoded 0 interrupt, 1 TLB modify, 2 TLB load, 3 TLB store, 4 address error load, 5 address error store, 6 syscall, 7 breakpoint, 8 reserved instruction, 9 coprocessor unusable, 10 overflow, 11 trap, 12 coprocessor-2 exception, 13 capability trap, 14 refill load, 15 refill store, 16 invalid load, 17 invalid store, 18 machine check; the reported `cause_exc_code` is 0x00, 0x01, 0x02, 0x03, 0x04, 0x05, 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0D, 0x12, 0x12, 0x02, 0x03, 0x02, 0x03, 0x18 respectively.
- R4: Cause values 19 to 31 are treated as machine check: code 0x18 and the common vector offset.
- R5: The vector offset is 0x180 when `status_exl` was 1; otherwise 0x080 for causes 14 and 15, 0x280 for cause 13 and 0x180 for every other cause.
- R6: The vector base is 0xFFFFFFFFBFC00200 when `status_bev` was 1 and 0xFFFFFFFF80000000 when it was 0; `redirect_pc` equals base plus offset minus `cap_base`, all using the status values held before the request edge.
- R7: Every sampled request sets `status_exl` to 1 and writes `cause_exc_code`, whatever the previous exception level.
- R8: `redirect_valid` is 1 for exactly the one cycle after each sampled request and 0 otherwise.
- R9: A `stat_load` without a request loads `status_exl` and `status_bev` from `stat_exl_in` and `stat_bev_in`; when both arrive together, `status_bev` is loaded but `status_exl` becomes 1.
- R10: Synchronous reset sets `epc`, `cause_bd`, `cause_exc_code`, `status_exl`, `redirect_pc` and `redirect_valid` to 0 and `status_bev` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception request strobe, one cycle per exception |
| exc_cause | input | 5 | Enumerated exception cause |
| cap_base | input | 64 | Capability base subtracted from the vector address |
| cur_pc | input | 64 | Address of the excepting instruction |
| in_delay_slot | input | 1 | Excepting instruction is in a branch delay slot |
| stat_load | input | 1 | Load the status bits from the two inputs below |
| stat_exl_in | input | 1 | Exception-level value for a status load |
| stat_bev_in | input | 1 | Boot-vector value for a status load |
| epc | output | 64 | Recorded exception return address |
| cause_bd | output | 1 | Recorded branch-delay flag |
| cause_exc_code | output | 5 | Code of the last exception |
| status_exl | output | 1 | Exception level |
| status_bev | output | 1 | Boot exception vectors selected |
| redirect_pc | output | 64 | Fetch redirect address |
| redirect_valid | output | 1 | One-cycle pulse qualifying `redirect_pc` |

## Verification
Every piece of state here reaches a port one edge after the request that writes it, so a wrong exception level, return address or vector choice is visible at the next clock rather than buried. A stale exception level shows up twice: as an overwritten return address when it should have been kept, and as a wrong vector offset on the same redirect. The bench sweeps all 32 cause values against both exception levels, both boot-vector settings and both delay-slot states, and checks each output one cycle after the request.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN    = 64;
    localparam int CAUSE_W = 5;
    localparam int CODE_W  = 5;
    localparam int OFF_W   = 12;

    typedef enum logic [CAUSE_W-1:0] {
        CS_INTERRUPT   = 5'd0,
        CS_TLB_MOD     = 5'd1,
        CS_TLB_LOAD    = 5'd2,
        CS_TLB_STORE   = 5'd3,
        CS_ADDR_LOAD   = 5'd4,
        CS_ADDR_STORE  = 5'd5,
        CS_SYSCALL     = 5'd6,
        CS_BREAK       = 5'd7,
        CS_RESV_INSN   = 5'd8,
        CS_COP_UNUSE   = 5'd9,
        CS_OVERFLOW    = 5'd10,
        CS_TRAP        = 5'd11,
        CS_COP2_EXC    = 5'd12,
        CS_CAP_TRAP    = 5'd13,
        CS_REFILL_LD   = 5'd14,
        CS_REFILL_ST   = 5'd15,
        CS_INVALID_LD  = 5'd16,
        CS_INVALID_ST  = 5'd17,
        CS_MACH_CHECK  = 5'd18
    } exc_cause_e;

    localparam logic [XLEN-1:0]  VEC_BASE_BOOT = 64'hFFFF_FFFF_BFC0_0200;
    localparam logic [XLEN-1:0]  VEC_BASE_RUN  = 64'hFFFF_FFFF_8000_0000;
    localparam logic [OFF_W-1:0] OFF_REFILL    = 12'h080;
    localparam logic [OFF_W-1:0] OFF_COMMON    = 12'h180;
    localparam logic [OFF_W-1:0] OFF_CAP_TRAP  = 12'h280;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              refill;
        logic              cap_trap;
    } cause_info_t;

    typedef struct packed {
        logic [XLEN-1:0]   ret_addr;
        logic              delay_flag;
        logic [CODE_W-1:0] code;
        logic [XLEN-1:0]   target;
    } exc_update_t;

    function automatic cause_info_t decode_cause(input logic [CAUSE_W-1:0] raw);
        cause_info_t info;
        info.refill   = 1'b0;
        info.cap_trap = 1'b0;
        case (raw)
            CS_INTERRUPT:  info.code = 5'h00;
            CS_TLB_MOD:    info.code = 5'h01;
            CS_TLB_LOAD:   info.code = 5'h02;
            CS_TLB_STORE:  info.code = 5'h03;
            CS_ADDR_LOAD:  info.code = 5'h04;
            CS_ADDR_STORE: info.code = 5'h05;
            CS_SYSCALL:    info.code = 5'h08;
            CS_BREAK:      info.code = 5'h09;
            CS_RESV_INSN:  info.code = 5'h0A;
            CS_COP_UNUSE:  info.code = 5'h0B;
            CS_OVERFLOW:   info.code = 5'h0C;
            CS_TRAP:       info.code = 5'h0D;
            CS_COP2_EXC:   info.code = 5'h12;
            CS_CAP_TRAP: begin
                info.code     = 5'h12;
                info.cap_trap = 1'b1;
            end
            CS_REFILL_LD: begin
                info.code   = 5'h02;
                info.refill = 1'b1;
            end
            CS_REFILL_ST: begin
                info.code   = 5'h03;
                info.refill = 1'b1;
            end
            CS_INVALID_LD: info.code = 5'h02;
            CS_INVALID_ST: info.code = 5'h03;
            default:       info.code = 5'h18;
        endcase
        return info;
    endfunction

    function automatic logic [XLEN-1:0] sext_offset(input logic [OFF_W-1:0] off);
        return {{(XLEN-OFF_W){off[OFF_W-1]}}, off};
    endfunction

endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode
    import exc_pkg::*;
(
    input  logic [CAUSE_W-1:0] cause_raw,
    output cause_info_t        info
);
    always_comb begin
        info = decode_cause(cause_raw);
    end

    always_comb begin
        assert (!(info.refill && info.cap_trap))
            else $error("AST_DECODE_EXCLUSIVE: refill and capability trap both flagged"); // R5
    end
endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
    import exc_pkg::*;
(
    input  logic            exl_now,
    input  logic            bev_now,
    input  cause_info_t     info,
    input  logic [XLEN-1:0] cap_base,
    output logic [XLEN-1:0] target
);
    logic [OFF_W-1:0] offset;
    logic [XLEN-1:0]  base;

    always_comb begin
        if (exl_now)
            offset = OFF_COMMON;
        else if (info.refill)
            offset = OFF_REFILL;
        else if (info.cap_trap)
            offset = OFF_CAP_TRAP;
        else
            offset = OFF_COMMON;
    end

    always_comb begin
        base   = bev_now ? VEC_BASE_BOOT : VEC_BASE_RUN;
        target = base + sext_offset(offset) - cap_base;
    end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
    import exc_pkg::*;
#(
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              delay_slot,
    input  logic [XLEN-1:0]   pc_now,
    input  logic [CODE_W-1:0] code_in,
    input  logic [XLEN-1:0]   target_in,
    input  logic              ld,
    input  logic              ld_exl,
    input  logic              ld_bev,
    output exc_update_t       upd_q,
    output logic              exl_q,
    output logic              bev_q,
    output logic              valid_q
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic [XLEN-1:0] ret_addr_next;

    always_comb begin
        ret_addr_next = delay_slot ? (pc_now - STEP) : pc_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_q   <= '0;
            exl_q   <= 1'b0;
            bev_q   <= 1'b1;
            valid_q <= 1'b0;
        end else begin
            valid_q <= req;
            if (ld)
                bev_q <= ld_bev;
            if (req) begin
                exl_q        <= 1'b1;
                upd_q.code   <= code_in;
                upd_q.target <= target_in;
                if (!exl_q) begin
                    upd_q.ret_addr   <= ret_addr_next;
                    upd_q.delay_flag <= delay_slot;
                end
            end else if (ld) begin
                exl_q <= ld_exl;
            end
        end
    end

    AST_EPC_HELD_AT_EXL: assert property (@(posedge clk) disable iff (rst)
        (req && exl_q) |=> ($stable(upd_q.ret_addr) && $stable(upd_q.delay_flag))) // R1
        else $error("AST_EPC_HELD_AT_EXL");

    AST_EPC_DELAY_SLOT: assert property (@(posedge clk) disable iff (rst)
        (req && !exl_q && delay_slot) |=> (upd_q.delay_flag && upd_q.ret_addr == $past(pc_now) - STEP)) // R2
        else $error("AST_EPC_DELAY_SLOT");

    AST_EPC_PLAIN: assert property (@(posedge clk) disable iff (rst)
        (req && !exl_q && !delay_slot) |=> (!upd_q.delay_flag && upd_q.ret_addr == $past(pc_now))) // R2
        else $error("AST_EPC_PLAIN");

    AST_EXL_SET: assert property (@(posedge clk) disable iff (rst)
        req |=> exl_q) // R7
        else $error("AST_EXL_SET");

    AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (rst)
        !req |=> !valid_q) // R8
        else $error("AST_REDIRECT_PULSE");

    AST_LOAD_EXL: assert property (@(posedge clk) disable iff (rst)
        (ld && !req) |=> (exl_q == $past(ld_exl) && bev_q == $past(ld_bev))) // R9
        else $error("AST_LOAD_EXL");
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_req,
    input  logic [4:0]        exc_cause,
    input  logic [63:0]       cap_base,
    input  logic [63:0]       cur_pc,
    input  logic              in_delay_slot,
    input  logic              stat_load,
    input  logic              stat_exl_in,
    input  logic              stat_bev_in,
    output logic [63:0]       epc,
    output logic              cause_bd,
    output logic [4:0]        cause_exc_code,
    output logic              status_exl,
    output logic              status_bev,
    output logic [63:0]       redirect_pc,
    output logic              redirect_valid
);
    cause_info_t     info;
    logic [XLEN-1:0] target;
    exc_update_t     upd_q;
    logic            exl_q;
    logic            bev_q;
    logic            valid_q;

    exc_cause_decode u_decode (
        .cause_raw (exc_cause),
        .info      (info)
    );

    exc_vector_calc u_vector (
        .exl_now  (exl_q),
        .bev_now  (bev_q),
        .info     (info),
        .cap_base (cap_base),
        .target   (target)
    );

    exc_state_regs #(
        .INSN_BYTES (INSN_BYTES)
    ) u_state (
        .clk        (clk),
        .rst        (rst),
        .req        (exc_req),
        .delay_slot (in_delay_slot),
        .pc_now     (cur_pc),
        .code_in    (info.code),
        .target_in  (target),
        .ld         (stat_load),
        .ld_exl     (stat_exl_in),
        .ld_bev     (stat_bev_in),
        .upd_q      (upd_q),
        .exl_q      (exl_q),
        .bev_q      (bev_q),
        .valid_q    (valid_q)
    );

    assign epc            = upd_q.ret_addr;
    assign cause_bd       = upd_q.delay_flag;
    assign cause_exc_code = upd_q.code;
    assign status_exl     = exl_q;
    assign status_bev     = bev_q;
    assign redirect_pc    = upd_q.target;
    assign redirect_valid = valid_q;

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        exc_req |=> (redirect_valid && status_exl)) // R8
        else $error("AST_VALID_AFTER_REQ");

    AST_UNUSED_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (exc_req && exc_cause > 5'd18) |=> (cause_exc_code == 5'h18)) // R4
        else $error("AST_UNUSED_CAUSE");
endmodule

// File: tb/tb_exc_entry_unit.sv
module tb_exc_entry_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        exc_req;
    logic [4:0]  exc_cause;
    logic [63:0] cap_base;
    logic [63:0] cur_pc;
    logic        in_delay_slot;
    logic        stat_load;
    logic        stat_exl_in;
    logic        stat_bev_in;
    logic [63:0] epc;
    logic        cause_bd;
    logic [4:0]  cause_exc_code;
    logic        status_exl;
    logic        status_bev;
    logic [63:0] redirect_pc;
    logic        redirect_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    exc_entry_unit dut (
        .clk            (clk),
        .rst            (rst),
        .exc_req        (exc_req),
        .exc_cause      (exc_cause),
        .cap_base       (cap_base),
        .cur_pc         (cur_pc),
        .in_delay_slot  (in_delay_slot),
        .stat_load      (stat_load),
        .stat_exl_in    (stat_exl_in),
        .stat_bev_in    (stat_bev_in),
        .epc            (epc),
        .cause_bd       (cause_bd),
        .cause_exc_code (cause_exc_code),
        .status_exl     (status_exl),
        .status_bev     (status_bev),
        .redirect_pc    (redirect_pc),
        .redirect_valid (redirect_valid)
    );

    function automatic logic [4:0] want_code(input int c);
        case (c)
            0: return 5'h00;   1: return 5'h01;
            2: return 5'h02;   3: return 5'h03;
            4: return 5'h04;   5: return 5'h05;
            6: return 5'h08;   7: return 5'h09;
            8: return 5'h0A;   9: return 5'h0B;
            10: return 5'h0C;  11: return 5'h0D;
            12: return 5'h12;  13: return 5'h12;
            14: return 5'h02;  15: return 5'h03;
            16: return 5'h02;  17: return 5'h03;
            default: return 5'h18;
        endcase
    endfunction

    function automatic logic [63:0] want_target(input int c, input bit exl, input bit bev,
                                                 input logic [63:0] cb);
        logic [63:0] off;
        logic [63:0] base;
        if (exl)                    off = 64'h180;
        else if (c == 14 || c == 15) off = 64'h080;
        else if (c == 13)           off = 64'h280;
        else                        off = 64'h180;
        base = bev ? 64'hFFFF_FFFF_BFC0_0200 : 64'hFFFF_FFFF_8000_0000;
        return base + off - cb;
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    logic [63:0] m_epc;
    logic        m_bd;

    task automatic run_case(input int c, input bit exl, input bit bev, input bit ds,
                            input logic [63:0] pc, input logic [63:0] cb);
        @(negedge clk);
        stat_load   = 1'b1;
        stat_exl_in = exl;
        stat_bev_in = bev;
        @(negedge clk);
        stat_load = 1'b0;
        check("R9", "status_exl after load", 64'(status_exl), 64'(exl));
        check("R9", "status_bev after load", 64'(status_bev), 64'(bev));
        exc_req       = 1'b1;
        exc_cause     = 5'(c);
        in_delay_slot = ds;
        cur_pc        = pc;
        cap_base      = cb;
        if (!exl) begin
            m_epc = ds ? pc - 64'd4 : pc;
            m_bd  = ds;
        end
        @(negedge clk);
        exc_req = 1'b0;
        check(exl ? "R1" : "R2", "epc", epc, m_epc);
        check(exl ? "R1" : "R2", "cause_bd", 64'(cause_bd), 64'(m_bd));
        check(c > 18 ? "R4" : "R3", "cause_exc_code", 64'(cause_exc_code), 64'(want_code(c)));
        check("R7", "status_exl", 64'(status_exl), 64'd1);
        check("R6", "redirect_pc", redirect_pc, want_target(c, exl, bev, cb));
        check("R8", "redirect_valid high", 64'(redirect_valid), 64'd1);
        @(negedge clk);
        check("R8", "redirect_valid low", 64'(redirect_valid), 64'd0);
    endtask

    initial begin
        rst = 1'b1;
        exc_req = 1'b0; exc_cause = '0; cap_base = '0; cur_pc = '0;
        in_delay_slot = 1'b0; stat_load = 1'b0; stat_exl_in = 1'b0; stat_bev_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10", "epc reset", epc, 64'd0);
        check("R10", "bd reset", 64'(cause_bd), 64'd0);
        check("R10", "code reset", 64'(cause_exc_code), 64'd0);
        check("R10", "exl reset", 64'(status_exl), 64'd0);
        check("R10", "bev reset", 64'(status_bev), 64'd1);
        check("R10", "redirect_pc reset", redirect_pc, 64'd0);
        check("R10", "redirect_valid reset", 64'(redirect_valid), 64'd0);
        m_epc = '0;
        m_bd  = 1'b0;

        for (int c = 0; c < 32; c++) begin
            for (int k = 0; k < 8; k++) begin
                logic [63:0] pc;
                logic [63:0] cb;
                pc = 64'h0000_0040_0000_1000 + 64'(c * 64 + k * 4) + (64'(k) << 40);
                cb = (k[1]) ? (64'h0000_0000_0001_0000 * 64'(c + 1)) + 64'(k) : 64'd0;
                run_case(c, k[0], k[1], k[2], pc, cb);
            end
        end

        // R9: load and request together, EXL forced, BEV taken from load
        @(negedge clk);
        stat_load = 1'b1; stat_exl_in = 1'b0; stat_bev_in = 1'b1;
        @(negedge clk);
        stat_exl_in = 1'b0; stat_bev_in = 1'b0;
        exc_req = 1'b1; exc_cause = 5'd13; in_delay_slot = 1'b0;
        cur_pc = 64'h1234_5678; cap_base = 64'h100;
        @(negedge clk);
        stat_load = 1'b0; exc_req = 1'b0;
        check("R9", "exl wins over load", 64'(status_exl), 64'd1);
        check("R9", "bev loaded with request", 64'(status_bev), 64'd0);
        check("R6", "target uses prior bev", redirect_pc, want_target(13, 1'b0, 1'b1, 64'h100));
        check("R2", "epc on combined", epc, 64'h1234_5678);

        // R8: idle cycles keep the pulse low
        repeat (3) begin
            @(negedge clk);
            check("R8", "idle redirect_valid", 64'(redirect_valid), 64'd0);
        end

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule